// File: doc/BRIEF.md
# Round-Trip Baud Delay Meter

This block measures how many whole baud periods pass between a rising edge on the transmit frame-sync input and the next rising edge on the receive frame-sync input. Each baud period is 12.5 µs, which matches an 80 kbaud line, and the system supplies it as a one-cycle baud tick. The block is used on a line-terminating port to estimate the loop delay of the link.

At the receive edge, the block packs the count and a snapshot of a 3-bit elastic-buffer state code into one 8-bit read-only status byte. Both fields are written on the same clock edge, so a host read never sees a mix of old and new fields. Software uses the state code to correct the raw count:

- code 110 needs no correction;
- code 000 means one baud is subtracted;
- code 010 means two bauds are subtracted.

Other codes appear only while the link is being activated.

The measurement is meaningful only in line-termination mode. While that mode flag is low, the status byte is held at 00h and nothing is counted.

Top module: `rtd_meter`

## Requirements
- R1: After reset the status byte reads 00h.
- R2: Status bits 4..0 hold the number of baud-tick cycles strictly between the clock cycle in which a transmit frame-sync rising edge is seen and the cycle in which the next receive frame-sync rising edge is seen. A tick in either of those two edge cycles is not counted.
- R3: Status bits 7..5 hold the elastic-buffer state input as sampled in the receive-edge cycle. Bits 7..5 and bits 4..0 change on the same clock edge.
- R4: The count saturates at 31 and does not wrap, however many ticks arrive before the receive edge.
- R5: The status byte changes only on the clock edge that samples an accepted receive rising edge, or when the mode flag clears it. Between these events it holds its value.
- R6: While the line-termination flag is low, the status byte becomes 00h on the next clock edge and stays there. Frame-sync edges and ticks seen while the flag is low have no effect.
- R7: A receive rising edge that arrives with no measurement pending is ignored. A measurement is pending after a transmit edge and until the receive edge that ends it.
- R8: A transmit rising edge that arrives while a measurement is pending restarts the count at zero. If transmit and receive rising edges arrive in the same cycle, the transmit edge wins and the receive edge is ignored.
- R9: Only rising edges count. A frame-sync input held high does not start or end a measurement a second time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| baud_tick | input | 1 | One-cycle enable marking one baud period |
| tx_fsync | input | 1 | Transmit frame-sync |
| rx_fsync | input | 1 | Receive frame-sync |
| lt_mode | input | 1 | Line-termination mode flag; measurement runs only while high |
| ebuf_state | input | 3 | Elastic-buffer state code to capture |
| status | output | 8 | {state code[2:0], baud count[4:0]} |

## Verification
The edge detectors combine the input with its registered previous value. The status register therefore updates on the first clock edge that samples a new rising edge, and the mode clear also lands on the first edge after the flag falls. The bench drives inputs on the falling clock edge and checks the status on the following falling edge, one cycle after each receive edge or mode change. Just before each receive edge, it also checks that the previous result is still held. Expected bytes are computed as the state code concatenated with the smaller of the tick count and 31.

// File: rtl/rtd_pkg.sv
package rtd_pkg;
  localparam int CNT_W  = 5;
  localparam int EB_W   = 3;
  localparam int STAT_W = CNT_W + EB_W;
  localparam int NUM_FS = 2;
  localparam int FS_TX  = 0;
  localparam int FS_RX  = 1;
endpackage

// File: rtl/rtd_edge_det.sv
module rtd_edge_det #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sig_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;
  logic [W-1:0] prev_d;

  always_comb prev_d = sig_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  for (genvar i = 0; i < W; i++) begin : g_rise
    assign rise_o[i] = sig_i[i] & ~prev_q[i];

    // R9: a rising edge is never reported on two cycles in a row
    a_r9_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o[i] |=> !rise_o[i]);
  end
endmodule

// File: rtl/rtd_baud_counter.sv
module rtd_baud_counter #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             restart_i,
  input  logic             stop_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             active_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             act_q, act_d;

  always_comb begin
    cnt_d = cnt_q;
    act_d = act_q;
    if (!en_i) begin
      cnt_d = '0;
      act_d = 1'b0;
    end else if (restart_i) begin
      cnt_d = '0;
      act_d = 1'b1;
    end else if (act_q && stop_i) begin
      act_d = 1'b0;
    end else if (act_q && tick_i && (cnt_q != CNT_MAX)) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign cnt_o    = cnt_q;
  assign active_o = act_q;

  // R4: once full, the counter stays full until restarted or disabled
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !restart_i && cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX);

  // R2: the count advances by at most one per cycle
  a_r2_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !restart_i) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/rtd_status_latch.sv
module rtd_status_latch #(
  parameter int CNT_W = 5,
  parameter int EB_W  = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr_i,
  input  logic                  cap_i,
  input  logic [CNT_W-1:0]      cnt_i,
  input  logic [EB_W-1:0]       eb_i,
  output logic [CNT_W+EB_W-1:0] status_o
);
  logic [CNT_W+EB_W-1:0] stat_q, stat_d;

  always_comb begin
    stat_d = stat_q;
    if (clr_i)      stat_d = '0;
    else if (cap_i) stat_d = {eb_i, cnt_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  assign status_o = stat_q;

  // R5: without a capture or clear, the byte holds
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !cap_i) |=> $stable(stat_q));
endmodule

// File: rtl/rtd_meter.sv
module rtd_meter #(
  parameter int CNT_W = rtd_pkg::CNT_W,
  parameter int EB_W  = rtd_pkg::EB_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  baud_tick,
  input  logic                  tx_fsync,
  input  logic                  rx_fsync,
  input  logic                  lt_mode,
  input  logic [EB_W-1:0]       ebuf_state,
  output logic [CNT_W+EB_W-1:0] status
);
  import rtd_pkg::*;

  logic [NUM_FS-1:0] fs_in, fs_rise;
  logic              tx_rise, rx_rise;
  logic [CNT_W-1:0]  cnt;
  logic              active;
  logic              capture;

  assign fs_in[FS_TX] = tx_fsync;
  assign fs_in[FS_RX] = rx_fsync;

  rtd_edge_det #(.W(NUM_FS)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .sig_i  (fs_in),
    .rise_o (fs_rise)
  );

  assign tx_rise = fs_rise[FS_TX];
  assign rx_rise = fs_rise[FS_RX];

  rtd_baud_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (lt_mode),
    .restart_i (tx_rise),
    .stop_i    (rx_rise),
    .tick_i    (baud_tick),
    .cnt_o     (cnt),
    .active_o  (active)
  );

  assign capture = lt_mode & active & rx_rise & ~tx_rise;

  rtd_status_latch #(.CNT_W(CNT_W), .EB_W(EB_W)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (!lt_mode),
    .cap_i    (capture),
    .cnt_i    (cnt),
    .eb_i     (ebuf_state),
    .status_o (status)
  );

  // R6: mode flag low forces a zero byte on the next edge
  a_r6_lt_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !lt_mode |=> status == '0);

  // R3: the state field follows the input sampled at an accepted receive edge
  a_r3_state_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (lt_mode && active && rx_rise && !tx_rise) |=>
      status[CNT_W+EB_W-1:CNT_W] == $past(ebuf_state));

  // R7: a receive edge with nothing pending leaves the byte untouched
  a_r7_orphan_rx: assert property (@(posedge clk) disable iff (!rst_n)
    (lt_mode && !active && rx_rise) |=> $stable(status));
endmodule

// File: tb/sim_rtd_meter.sv
module sim_rtd_meter;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       baud_tick, tx_fsync, rx_fsync, lt_mode;
  logic [2:0] ebuf_state;
  logic [7:0] status;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [7:0] exp_status;

  rtd_meter u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .baud_tick  (baud_tick),
    .tx_fsync   (tx_fsync),
    .rx_fsync   (rx_fsync),
    .lt_mode    (lt_mode),
    .ebuf_state (ebuf_state),
    .status     (status)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_tx(input bit with_tick);
    tx_fsync = 1'b1; baud_tick = with_tick;
    step();
    tx_fsync = 1'b0; baud_tick = 1'b0;
  endtask

  task automatic ticks(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      baud_tick = 1'b1;
      step();
      baud_tick = 1'b0;
      for (int g = 0; g < gap; g++) step();
    end
  endtask

  task automatic pulse_rx(input logic [2:0] eb, input bit with_tick);
    rx_fsync = 1'b1; ebuf_state = eb; baud_tick = with_tick;
    step();
    rx_fsync = 1'b0; baud_tick = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; baud_tick = 1'b0; tx_fsync = 1'b0; rx_fsync = 1'b0;
    lt_mode = 1'b1; ebuf_state = 3'b000;
    step(); step();
    rst_n = 1'b1;
    step();
    exp_status = 8'h00;
    check(status, exp_status, "R1 reset value");

    // R2 R3 R4 R5: sweep counts past saturation with every state code
    for (int n = 0; n <= 33; n++) begin
      logic [2:0] eb;
      eb = 3'(n % 8);
      pulse_tx(n % 2 == 1);
      ticks(n, n % 3);
      check(status, exp_status, "R5 hold before rx edge");
      pulse_rx(eb, n % 2 == 1);
      exp_status = {eb, 5'((n > 31) ? 31 : n)};
      check(status, exp_status, (n > 31) ? "R4 saturate" : "R2 R3 count and state");
    end

    // R7: receive edge with nothing pending
    ticks(3, 0);
    pulse_rx(3'b010, 1'b0);
    check(status, exp_status, "R7 orphan rx ignored");

    // R8: restart while pending
    pulse_tx(1'b0); ticks(5, 1);
    pulse_tx(1'b0); ticks(3, 0);
    pulse_rx(3'b110, 1'b0);
    exp_status = {3'b110, 5'd3};
    check(status, exp_status, "R8 restart count");

    // R8: tx and rx edges together, tx wins
    pulse_tx(1'b0); ticks(4, 0);
    tx_fsync = 1'b1; rx_fsync = 1'b1; ebuf_state = 3'b111;
    step();
    tx_fsync = 1'b0; rx_fsync = 1'b0;
    check(status, exp_status, "R8 simultaneous edges keep old byte");
    ticks(1, 0);
    pulse_rx(3'b000, 1'b0);
    exp_status = {3'b000, 5'd1};
    check(status, exp_status, "R8 tx wins then new count");

    // R9: rx held high does not end the next measurement
    pulse_tx(1'b0); ticks(4, 0);
    rx_fsync = 1'b1; ebuf_state = 3'b010;
    step();
    exp_status = {3'b010, 5'd4};
    check(status, exp_status, "R9 first rx edge");
    pulse_tx(1'b0); ticks(2, 0);
    step();
    check(status, exp_status, "R9 level high ignored");
    rx_fsync = 1'b0;
    step();
    rx_fsync = 1'b1; ebuf_state = 3'b110;
    step();
    rx_fsync = 1'b0;
    exp_status = {3'b110, 5'd2};
    check(status, exp_status, "R9 next real edge");

    // R6: mode flag low clears and blocks measurement
    lt_mode = 1'b0;
    step();
    exp_status = 8'h00;
    check(status, exp_status, "R6 clear on mode low");
    pulse_tx(1'b0); ticks(6, 0);
    pulse_rx(3'b110, 1'b0);
    check(status, exp_status, "R6 no measurement while low");
    lt_mode = 1'b1;
    step();
    pulse_rx(3'b010, 1'b0);
    check(status, exp_status, "R6 R7 nothing pending after mode returns");
    pulse_tx(1'b0); ticks(7, 2);
    pulse_rx(3'b000, 1'b0);
    exp_status = {3'b000, 5'd7};
    check(status, exp_status, "R6 measurement resumes");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule